// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Reference-Bit Replacement

This block caches page translations for a processor's load/store path. A 48-bit virtual address is cut into a 36-bit virtual page number (upper bits) and a 12-bit page offset (lower bits). The page number is compared against every valid entry in parallel. On a match the block returns, in the same cycle, a 45-bit physical address. That address is the stored 33-bit physical page number followed by the untouched offset. The same cycle also reports a permission fault and the entry's dirty state. When nothing matches, a miss is reported so that the surrounding logic can consult the page table. It then returns the translation through the refill port.

Each entry carries a tag, a physical page number, two permission bits, a valid flag, a reference flag and a dirty flag. Hardware sets an entry's reference flag whenever a lookup hits it. A clear input wipes all reference flags at once, and the surrounding logic pulses it periodically. The replacement choice then favours entries that have not been used since the last clear, which approximates least-recently-used replacement. A flush input empties the whole buffer in one cycle.

The lookup side has no back-pressure: a lookup presented with `lk_valid` is answered combinationally and always consumed at the next edge. The refill side is valid/ready. A refill transfers on an edge where both `rf_valid` and `rf_ready` are high, and `rf_ready` is low exactly in cycles where `flush` is high. The refill source may hold `rf_valid` with stable data until it sees `rf_ready`.

Top module: `vpn_xlat_buf`

## Requirements
- R1: When `lk_valid` is high and a valid entry's tag equals `lk_vaddr[47:12]`, `lk_hit` is high and `lk_miss` low in that same cycle. When `lk_valid` is high with no match, `lk_miss` is high and `lk_hit` low. When `lk_valid` is low, both are low.
- R2: On a hit, `lk_paddr` equals {stored physical page number, `lk_vaddr[11:0]`}, so the low 12 bits pass through unchanged. On a miss it is zero.
- R3: Permission bit 0 allows reads and bit 1 allows writes. `lk_fault` is high on a hit whose access kind (`lk_write` = 1 for write) lacks its permission bit. It is never high without a hit.
- R4: `lk_dirty` shows the hit entry's dirty flag before the access. A permitted write hit sets the flag from the next cycle. A faulting write leaves it clear. A refill installs the entry clean.
- R5: `rf_ready` equals the inverse of `flush`. An accepted refill is visible to lookups from the next cycle and is installed with its reference flag set.
- R6: A refill whose page number already sits in a valid entry overwrites that entry, so no two valid entries ever share a tag.
- R7: Otherwise the refill goes to the lowest-numbered invalid entry.
- R8: If every entry is valid, the refill goes to the lowest-numbered entry whose reference flag is clear.
- R9: If every entry is valid and referenced, a rotating pointer picks the victim. The pointer is 0 after reset and advances by one, wrapping at the depth, each time it is used.
- R10: Any hit lookup sets its entry's reference flag. A `ref_clear` pulse clears all reference flags in one cycle, but a hit in the same cycle leaves its own entry referenced.
- R11: A `flush` cycle invalidates every entry by the next cycle. A refill offered in that cycle is not taken. A lookup in that cycle changes no flag.
- R12: After reset every entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 48 | Virtual address: page number [47:12], offset [11:0] |
| lk_write | input | 1 | Lookup is a write (1) or read (0) |
| ref_clear | input | 1 | Clear all reference flags |
| flush | input | 1 | Invalidate all entries |
| rf_valid | input | 1 | Refill entry offered |
| rf_ready | output | 1 | Refill can be accepted this cycle |
| rf_vpn | input | 36 | Refill virtual page number |
| rf_ppn | input | 33 | Refill physical page number |
| rf_perm | input | 2 | Refill permissions: bit 0 read, bit 1 write |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_miss | output | 1 | Lookup found no valid entry |
| lk_fault | output | 1 | Hit whose access kind is not permitted |
| lk_dirty | output | 1 | Dirty flag of the hit entry before this access |
| lk_paddr | output | 45 | Physical address on a hit, zero otherwise |

## Verification
Lookups are applied with offsets at both ends of the 12-bit range and with every combination of permission bits and access kind. This separates a correct address splice and fault decode from one that mixes up read and write rights, and from one that dirties an entry on a faulting write. Replacement is driven through four fill states: one invalid hole among stale entries, all valid with some unreferenced, all valid and all referenced, and a refill of a page already held. After each refill, every page ever installed is probed to tell which entry was evicted. A same-cycle clear and hit, and a same-cycle flush and refill, separate the intended priority from the reversed one.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // permission bit positions inside an entry
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;

  // which rule chose the refill slot
  typedef enum logic [1:0] {
    VIC_SAME    = 2'd0,
    VIC_INVALID = 2'd1,
    VIC_UNREF   = 2'd2,
    VIC_RR      = 2'd3
  } vic_src_e;
endpackage

// File: rtl/xlat_entry_array.sv
module xlat_entry_array #(
  parameter int DEPTH  = 16,
  parameter int VPN_W  = 36,
  parameter int PPN_W  = 33,
  parameter int PERM_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [VPN_W-1:0]         look_vpn,
  input  logic [VPN_W-1:0]         rf_vpn,
  input  logic                     touch,
  input  logic                     set_dirty,
  input  logic                     ref_clear,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [PPN_W-1:0]         wr_ppn,
  input  logic [PERM_W-1:0]        wr_perm,
  output logic [DEPTH-1:0]         match_vec,
  output logic [DEPTH-1:0]         same_vec,
  output logic [DEPTH-1:0]         valid_vec,
  output logic [DEPTH-1:0]         ref_vec,
  output logic [PPN_W-1:0]         hit_ppn,
  output logic [PERM_W-1:0]        hit_perm,
  output logic                     hit_dirty
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [PPN_W-1:0]  ppn_arr  [DEPTH];
  logic [PERM_W-1:0] perm_arr [DEPTH];
  logic [DEPTH-1:0]  dirty_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [VPN_W-1:0]  tag_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [PERM_W-1:0] perm_q;
    logic              v_q, r_q, d_q;
    logic              sel;

    assign sel          = wr_en && (wr_idx == IDX_W'(g));
    assign match_vec[g] = v_q && (tag_q == look_vpn);
    assign same_vec[g]  = v_q && (tag_q == rf_vpn);
    assign valid_vec[g] = v_q;
    assign ref_vec[g]   = r_q;
    assign dirty_vec[g] = d_q;
    assign ppn_arr[g]   = ppn_q;
    assign perm_arr[g]  = perm_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q  <= '0;
        ppn_q  <= '0;
        perm_q <= '0;
        v_q    <= 1'b0;
        r_q    <= 1'b0;
        d_q    <= 1'b0;
      end else if (flush) begin
        v_q <= 1'b0;
      end else if (sel) begin
        tag_q  <= rf_vpn;
        ppn_q  <= wr_ppn;
        perm_q <= wr_perm;
        v_q    <= 1'b1;
        r_q    <= 1'b1;
        d_q    <= 1'b0;
      end else begin
        if (ref_clear)               r_q <= 1'b0;
        if (touch && match_vec[g])   r_q <= 1'b1;
        if (set_dirty && match_vec[g]) d_q <= 1'b1;
      end
    end
  end

  // one-hot OR mux of the matching entry
  always_comb begin
    hit_ppn   = '0;
    hit_perm  = '0;
    hit_dirty = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match_vec[i]) begin
        hit_ppn   = hit_ppn  | ppn_arr[i];
        hit_perm  = hit_perm | perm_arr[i];
        hit_dirty = hit_dirty | dirty_vec[i];
      end
    end
  end

  // R6
  unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R11
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));

  // R10
  ref_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_clear && !touch && !flush && !wr_en) |=> (ref_vec == '0));
endmodule

// File: rtl/xlat_victim_pick.sv
module xlat_victim_pick
  import xlat_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DEPTH-1:0]         valid_vec,
  input  logic [DEPTH-1:0]         ref_vec,
  input  logic [DEPTH-1:0]         same_vec,
  input  logic                     accept,
  output logic [$clog2(DEPTH)-1:0] vic_idx
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] same_idx, inv_idx, unref_idx;
  logic             has_same, has_inv, has_unref;
  vic_src_e         src;

  always_comb begin
    same_idx  = '0; has_same  = 1'b0;
    inv_idx   = '0; has_inv   = 1'b0;
    unref_idx = '0; has_unref = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (same_vec[i])                begin same_idx  = IDX_W'(i); has_same  = 1'b1; end
      if (!valid_vec[i])              begin inv_idx   = IDX_W'(i); has_inv   = 1'b1; end
      if (valid_vec[i] && !ref_vec[i]) begin unref_idx = IDX_W'(i); has_unref = 1'b1; end
    end
    if (has_same)       src = VIC_SAME;
    else if (has_inv)   src = VIC_INVALID;
    else if (has_unref) src = VIC_UNREF;
    else                src = VIC_RR;
    case (src)
      VIC_SAME:    vic_idx = same_idx;
      VIC_INVALID: vic_idx = inv_idx;
      VIC_UNREF:   vic_idx = unref_idx;
      default:     vic_idx = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (accept && src == VIC_RR) begin
      ptr_q <= (ptr_q == IDX_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  // R7
  hole_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && same_vec == '0 && !(&valid_vec)) |-> !valid_vec[vic_idx]);

  // R8
  stale_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && same_vec == '0 && (&valid_vec) && !(&ref_vec))
      |-> !ref_vec[vic_idx]);

  // R9
  rotate_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&valid_vec) && (&ref_vec) && same_vec == '0) |-> (src == VIC_RR));
endmodule

// File: rtl/vpn_xlat_buf.sv
module vpn_xlat_buf
  import xlat_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int VPN_W  = 36,
  parameter int PPN_W  = 33,
  parameter int OFS_W  = 12,
  parameter int PERM_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_valid,
  input  logic [VPN_W+OFS_W-1:0]  lk_vaddr,
  input  logic                    lk_write,
  input  logic                    ref_clear,
  input  logic                    flush,
  input  logic                    rf_valid,
  output logic                    rf_ready,
  input  logic [VPN_W-1:0]        rf_vpn,
  input  logic [PPN_W-1:0]        rf_ppn,
  input  logic [PERM_W-1:0]       rf_perm,
  output logic                    lk_hit,
  output logic                    lk_miss,
  output logic                    lk_fault,
  output logic                    lk_dirty,
  output logic [PPN_W+OFS_W-1:0]  lk_paddr
);
  localparam int VA_W  = VPN_W + OFS_W;
  localparam int IDX_W = $clog2(DEPTH);

  initial depth_range_chk: assert (DEPTH >= 2 && DEPTH <= 64 && PERM_W >= 2);

  logic [VPN_W-1:0]  look_vpn;
  logic [OFS_W-1:0]  look_ofs;
  logic [DEPTH-1:0]  match_vec, same_vec, valid_vec, ref_vec;
  logic [PPN_W-1:0]  hit_ppn;
  logic [PERM_W-1:0] hit_perm;
  logic              hit_dirty, any_match, allowed, accept;
  logic              touch, set_dirty;
  logic [IDX_W-1:0]  vic_idx;

  assign look_vpn  = lk_vaddr[VA_W-1:OFS_W];
  assign look_ofs  = lk_vaddr[OFS_W-1:0];
  assign any_match = |match_vec;
  assign allowed   = lk_write ? hit_perm[PERM_WR] : hit_perm[PERM_RD];

  assign lk_hit   = lk_valid && any_match;
  assign lk_miss  = lk_valid && !any_match;
  assign lk_fault = lk_hit && !allowed;
  assign lk_dirty = lk_hit && hit_dirty;
  assign lk_paddr = lk_hit ? {hit_ppn, look_ofs} : '0;

  assign rf_ready  = !flush;
  assign accept    = rf_valid && rf_ready;
  assign touch     = lk_valid && !flush;
  assign set_dirty = touch && lk_write && any_match && allowed;

  xlat_entry_array #(
    .DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_vpn  (look_vpn),
    .rf_vpn    (rf_vpn),
    .touch     (touch),
    .set_dirty (set_dirty),
    .ref_clear (ref_clear),
    .flush     (flush),
    .wr_en     (accept),
    .wr_idx    (vic_idx),
    .wr_ppn    (rf_ppn),
    .wr_perm   (rf_perm),
    .match_vec (match_vec),
    .same_vec  (same_vec),
    .valid_vec (valid_vec),
    .ref_vec   (ref_vec),
    .hit_ppn   (hit_ppn),
    .hit_perm  (hit_perm),
    .hit_dirty (hit_dirty)
  );

  xlat_victim_pick #(.DEPTH(DEPTH)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .ref_vec   (ref_vec),
    .same_vec  (same_vec),
    .accept    (accept),
    .vic_idx   (vic_idx)
  );

  // R1
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_valid && !lk_miss));

  // R3
  fault_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);
endmodule

// File: tb/vpn_xlat_buf_bench.sv
`timescale 1ns/1ps
module vpn_xlat_buf_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0, ref_clear = 1'b0, flush = 1'b0;
  logic [47:0] lk_vaddr = '0;
  logic        rf_valid = 1'b0;
  logic        rf_ready;
  logic [35:0] rf_vpn = '0;
  logic [32:0] rf_ppn = '0;
  logic [1:0]  rf_perm = '0;
  logic        lk_hit, lk_miss, lk_fault, lk_dirty;
  logic [44:0] lk_paddr;

  always #10 clk = ~clk;

  vpn_xlat_buf u_vpn_xlat_buf (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .ref_clear(ref_clear), .flush(flush),
    .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_vpn(rf_vpn),
    .rf_ppn(rf_ppn), .rf_perm(rf_perm), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_fault(lk_fault), .lk_dirty(lk_dirty), .lk_paddr(lk_paddr)
  );

  typedef struct {
    logic        hit;
    logic        fault;
    logic        dirty;
    logic [44:0] pa;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  logic [35:0] seen[$];

  // reference model built from the requirements
  logic [35:0] m_vpn [N];
  logic [32:0] m_ppn [N];
  logic [1:0]  m_perm[N];
  logic        m_v[N], m_r[N], m_d[N];
  int          m_ptr = 0;

  function automatic int find(input logic [35:0] vpn);
    int h = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) h = i;
    return h;
  endfunction

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (lk_valid) begin
        exp_t e;
        n_chk++;
        if (q.size() == 0) begin
          n_bad++;
          $display("FAIL R1: no expected item, hit=%0b", lk_hit);
        end else begin
          e = q.pop_front();
          if (lk_hit !== e.hit || lk_miss !== !e.hit ||
              (e.hit && (lk_fault !== e.fault || lk_dirty !== e.dirty || lk_paddr !== e.pa))) begin
            n_bad++;
            $display("FAIL %s: hit/miss/fault/dirty/pa=%0b/%0b/%0b/%0b/%h expected %0b/%0b/%0b/%0b/%h",
                     e.req, lk_hit, lk_miss, lk_fault, lk_dirty, lk_paddr,
                     e.hit, !e.hit, e.fault, e.dirty, e.pa);
          end
        end
      end else begin
        n_chk++;
        if (lk_hit || lk_miss) begin
          n_bad++;
          $display("FAIL R1: idle hit/miss=%0b/%0b expected 0/0", lk_hit, lk_miss);
        end
      end
    end
  end

  // driver: one lookup per cycle; entry and exit at posedge+1
  task automatic look(input logic [35:0] vpn, input logic [11:0] ofs, input logic wr,
                      input logic clr, input logic fl, input string req);
    exp_t e;
    int h = find(vpn);
    e.hit = (h >= 0); e.fault = 1'b0; e.dirty = 1'b0; e.pa = '0; e.req = req;
    if (h >= 0) begin
      e.fault = wr ? !m_perm[h][1] : !m_perm[h][0];
      e.dirty = m_d[h];
      e.pa    = {m_ppn[h], ofs};
    end
    q.push_back(e);
    lk_valid = 1'b1; lk_vaddr = {vpn, ofs}; lk_write = wr; ref_clear = clr; flush = fl;
    @(posedge clk); #1;
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    end else begin
      if (clr) for (int i = 0; i < N; i++) m_r[i] = 1'b0;
      if (h >= 0) begin
        m_r[h] = 1'b1;
        if (wr && m_perm[h][1]) m_d[h] = 1'b1;
      end
    end
    lk_valid = 1'b0; lk_write = 1'b0; ref_clear = 1'b0; flush = 1'b0;
  endtask

  task automatic refill(input logic [35:0] vpn, input logic [32:0] ppn,
                        input logic [1:0] perm, input logic fl, input string req);
    int v = find(vpn);
    if (v < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) v = i;
    if (v < 0) for (int i = N - 1; i >= 0; i--) if (!m_r[i]) v = i;
    rf_valid = 1'b1; rf_vpn = vpn; rf_ppn = ppn; rf_perm = perm; flush = fl;
    @(negedge clk);
    n_chk++;
    if (rf_ready !== !fl) begin
      n_bad++;
      $display("FAIL R5: rf_ready=%0b expected %0b (%s)", rf_ready, !fl, req);
    end
    @(posedge clk); #1;
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    end else begin
      if (v < 0) begin
        v = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
      m_vpn[v] = vpn; m_ppn[v] = ppn; m_perm[v] = perm;
      m_v[v] = 1'b1; m_r[v] = 1'b1; m_d[v] = 1'b0;
      if (find(vpn) >= 0) seen.push_back(vpn);
    end
    rf_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic clear_refs();
    ref_clear = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) m_r[i] = 1'b0;
    ref_clear = 1'b0;
  endtask

  task automatic probe(input string req);
    for (int k = 0; k < seen.size(); k++)
      look(seen[k], 12'(12'h0A5 + k), 1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin : watchdog
    #(100000 * 20);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stimulus
    for (int i = 0; i < N; i++) begin
      m_v[i] = 1'b0; m_r[i] = 1'b0; m_d[i] = 1'b0;
      m_vpn[i] = '0; m_ppn[i] = '0; m_perm[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12: empty after reset
    look(36'd5, 12'h000, 1'b0, 1'b0, 1'b0, "R12");

    // fill all entries; perm = i%4 covers every permission pair
    for (int i = 0; i < N; i++)
      refill(36'd100 + 36'(i), 33'h1000 + 33'(i * 7), 2'(i % 4), 1'b0, "R5");

    // R1/R2 offsets at both ends
    look(36'd103, 12'hFFF, 1'b0, 1'b0, 1'b0, "R1");
    look(36'd107, 12'h000, 1'b0, 1'b0, 1'b0, "R2");
    look(36'hFEDCBA987, 12'h123, 1'b0, 1'b0, 1'b0, "R1");
    // R3 no rights at all
    look(36'd100, 12'h010, 1'b0, 1'b0, 1'b0, "R3");
    look(36'd100, 12'h010, 1'b1, 1'b0, 1'b0, "R3");
    // R4 write-only entry: permitted write, then read shows dirty
    look(36'd102, 12'h020, 1'b1, 1'b0, 1'b0, "R4");
    look(36'd102, 12'h020, 1'b0, 1'b0, 1'b0, "R4");
    // R4 read-only entry: faulting write leaves it clean
    look(36'd101, 12'h030, 1'b1, 1'b0, 1'b0, "R4");
    look(36'd101, 12'h030, 1'b0, 1'b0, 1'b0, "R4");

    // R9 all valid and referenced: rotating pointer
    refill(36'd200, 33'h2000, 2'b11, 1'b0, "R9");
    refill(36'd201, 33'h2001, 2'b11, 1'b0, "R9");
    probe("R9");
    refill(36'd202, 33'h2002, 2'b11, 1'b0, "R9");
    probe("R9");

    // R8 lowest unreferenced entry
    clear_refs();
    look(36'd200, 12'h001, 1'b0, 1'b0, 1'b0, "R8");
    look(36'd201, 12'h002, 1'b0, 1'b0, 1'b0, "R8");
    refill(36'd203, 33'h2003, 2'b01, 1'b0, "R8");
    probe("R8");

    // R6 refill of a held page overwrites in place
    refill(36'd105, 33'h1ABCDEF01, 2'b11, 1'b0, "R6");
    probe("R6");

    // R10 clear in the same cycle as a hit keeps that entry referenced
    look(36'd200, 12'h044, 1'b1, 1'b1, 1'b0, "R10");
    refill(36'd204, 33'h2004, 2'b11, 1'b0, "R10");
    probe("R10");

    // R11 flush: lookup in that cycle, refill blocked, everything gone
    look(36'd103, 12'h055, 1'b1, 1'b0, 1'b1, "R11");
    refill(36'd300, 33'h3000, 2'b11, 1'b1, "R11");
    look(36'd300, 12'h056, 1'b0, 1'b0, 1'b0, "R11");
    probe("R11");

    // R7 one hole among stale entries is filled first
    for (int i = 0; i < N - 1; i++)
      refill(36'd400 + 36'(i), 33'h4000 + 33'(i), 2'b11, 1'b0, "R7");
    clear_refs();
    refill(36'd500, 33'h5000, 2'b11, 1'b0, "R7");
    probe("R7");

    @(posedge clk); #1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule